// File: doc/BRIEF.md
# Decimal Sign-Magnitude ALU with Digit Shifts

This unit performs arithmetic on signed decimal numbers held as a sign bit and a magnitude of packed BCD digits (four digits by default, one nibble each, least significant digit in bits 3:0). It offers four functions chosen by a two-bit code: decimal add, decimal subtract, shift left by whole digits (multiply by a power of ten) and shift right by whole digits (divide by a power of ten, truncating). Add and subtract work digit by digit with decimal carry correction, and handle operands of either sign, so a subtraction may yield a negative result.

A request is presented with `in_valid` and is captured on the next rising clock edge; the result and its flags appear on the outputs in the following cycle and stay there until the next request. The second operand is either the register-style operand `b_sign`/`b_mag` or a single decimal digit `imm`; shifts always take their digit count from `imm`. Flags report a zero result, a strictly positive result (used for a branch-if-greater-than-zero decision), a magnitude overflow past 9999 and an operand that is not valid BCD.

A two-state machine tracks whether the outputs hold a fresh result. ST_IDLE: no result was captured on the last edge, `out_valid` is low. ST_HOLD: a result was captured on the last edge, `out_valid` is high. Transitions: ST_IDLE to ST_HOLD and ST_HOLD to ST_HOLD when `in_valid` is high at the edge; ST_HOLD to ST_IDLE and ST_IDLE to ST_IDLE when it is low.

Top module: `dalu_top`

## Requirements
- R1: With `fn`=00 (add) the result is the signed decimal sum of operand A and the second operand, with every result nibble in 0..9.
- R2: With `fn`=01 (subtract) the result is operand A minus the second operand; a negative difference gives `res_sign`=1 and the magnitude of the difference.
- R3: When the true add/subtract magnitude exceeds 9999, `res_mag` holds that magnitude modulo 10000 and `flag_ovf`=1; shifts never set `flag_ovf`.
- R4: With `fn`=10 the magnitude of A moves left by `imm` digits, zero digits enter at the low end, digits pushed past the top are lost, a count of 4 or more gives 0, and the sign of A is kept.
- R5: With `fn`=11 the magnitude of A moves right by `imm` digits, the lowest `imm` digits are dropped, a count of 4 or more gives 0, and the sign of A is kept.
- R6: When `use_imm`=1 an add or subtract uses `imm` as a positive one-digit second operand and `b_sign`/`b_mag` have no effect; shifts ignore `b_sign`, `b_mag` and `use_imm`.
- R7: `flag_zero`=1 exactly when all result digits are 0, and a zero result always has `res_sign`=0.
- R8: `flag_pos`=1 exactly when the result is nonzero and `res_sign`=0.
- R9: A nibble above 9 in `a_mag`, in `b_mag` when it is used, or in `imm` when it is used, sets `flag_bad`=1 and forces `res_mag`=0, `res_sign`=0, `flag_zero`=1, `flag_pos`=0, `flag_ovf`=0.
- R10: A request with `in_valid`=1 at a rising edge appears on the outputs after that edge with `out_valid`=1; after an edge with `in_valid`=0, `out_valid`=0 and all result outputs keep their values.
- R11: After reset `out_valid`=0, `res_mag`=0, `res_sign`=0, `flag_zero`=1 and the other flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| fn | input | 2 | Function: 00 add, 01 subtract, 10 shift left, 11 shift right |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | 16 | BCD magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | 16 | BCD magnitude of operand B |
| use_imm | input | 1 | Use `imm` instead of B for add/subtract |
| imm | input | 4 | Immediate digit or shift count |
| out_valid | output | 1 | Result captured on the last edge |
| res_sign | output | 1 | Sign of the result |
| res_mag | output | 16 | BCD magnitude of the result |
| flag_zero | output | 1 | Result is zero |
| flag_pos | output | 1 | Result is greater than zero |
| flag_ovf | output | 1 | Magnitude wrapped past 9999 |
| flag_bad | output | 1 | An operand used was not valid BCD |

## Verification
A wrong carry or correction inside one digit shows as a non-BCD nibble or an off-by-ten value in `res_mag` in the cycle right after the request, and a wrong choice between the direct difference and its recomplement shows there as a sign flip or a magnitude of 10000 minus the true one. A bad capture or hold condition in the state machine shows as `out_valid` or result outputs changing one cycle after an edge with `in_valid` low. Every request is compared against a model in the bench one cycle after it is driven, so any such fault appears at most one cycle after the operand pattern that triggers it.

// File: rtl/dalu_pkg.sv
package dalu_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_SHL = 2'b10,
        FN_SHR = 2'b11
    } dalu_fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dalu_state_e;

endpackage

// File: rtl/dalu_digit_add.sv
module dalu_digit_add (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       cin,
    output logic [3:0] s,
    output logic       cout
);
    logic [4:0] raw;

    always_comb begin
        raw = {1'b0, x} + {1'b0, y} + {4'b0000, cin};
        if (raw > 5'd9) begin
            s    = raw[3:0] + 4'd6;
            cout = 1'b1;
        end else begin
            s    = raw[3:0];
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/dalu_bcd_add.sv
module dalu_bcd_add #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] x,
    input  logic [4*DIGITS-1:0] y,
    input  logic                cin,
    output logic [4*DIGITS-1:0] s,
    output logic                cout
);
    logic [DIGITS:0] carry;

    assign carry[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        dalu_digit_add u_dig (
            .x    (x[4*g +: 4]),
            .y    (y[4*g +: 4]),
            .cin  (carry[g]),
            .s    (s[4*g +: 4]),
            .cout (carry[g+1])
        );
    end

    assign cout = carry[DIGITS];
endmodule

// File: rtl/dalu_bcd_check.sv
module dalu_bcd_check #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] value,
    output logic                ok
);
    logic [DIGITS-1:0] dig_ok;

    for (genvar g = 0; g < DIGITS; g++) begin : g_chk
        assign dig_ok[g] = (value[4*g +: 4] <= 4'd9);
    end

    assign ok = &dig_ok;
endmodule

// File: rtl/dalu_dshift.sv
module dalu_dshift #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] din,
    input  logic [3:0]          count,
    input  logic                to_left,
    output logic [4*DIGITS-1:0] dout
);
    int src;

    always_comb begin
        dout = '0;
        src  = 0;
        for (int i = 0; i < DIGITS; i++) begin
            src = to_left ? (i - int'(count)) : (i + int'(count));
            if (src >= 0 && src < DIGITS) begin
                dout[4*i +: 4] = din[4*src +: 4];
            end
        end
    end
endmodule

// File: rtl/dalu_top.sv
module dalu_top
    import dalu_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int MAG_W = 4 * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       fn,
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    input  logic             use_imm,
    input  logic [3:0]       imm,
    output logic             out_valid,
    output logic             res_sign,
    output logic [MAG_W-1:0] res_mag,
    output logic             flag_zero,
    output logic             flag_pos,
    output logic             flag_ovf,
    output logic             flag_bad
);
    dalu_state_e state_q, state_d;
    dalu_fn_e    op;

    logic             is_arith, is_sub, is_shift;
    logic             a_ok, b_ok, imm_ok, bad;
    logic [MAG_W-1:0] opb_mag, opb_nine, add_y;
    logic             opb_neg, same_sign;
    logic [MAG_W-1:0] sum1, sum1_nine, sum2, sh_out;
    logic             c1, c2_unused;
    logic [MAG_W-1:0] nx_mag;
    logic             nx_sign, nx_ovf, nx_zero, nx_pos;

    assign op       = dalu_fn_e'(fn);
    assign is_arith = (op == FN_ADD) || (op == FN_SUB);
    assign is_sub   = (op == FN_SUB);
    assign is_shift = !is_arith;

    // operand validity
    dalu_bcd_check #(.DIGITS(DIGITS)) u_chk_a (.value(a_mag), .ok(a_ok));
    dalu_bcd_check #(.DIGITS(DIGITS)) u_chk_b (.value(b_mag), .ok(b_ok));
    assign imm_ok = (imm <= 4'd9);
    assign bad    = !a_ok
                 || (is_arith && !use_imm && !b_ok)
                 || ((is_shift || use_imm) && !imm_ok);

    // second operand, with the subtract folded into its sign
    assign opb_mag = use_imm ? {{(MAG_W-4){1'b0}}, imm} : b_mag;
    assign opb_neg = (use_imm ? 1'b0 : b_sign) ^ is_sub;
    assign same_sign = (a_sign == opb_neg);

    always_comb begin
        for (int i = 0; i < DIGITS; i++) begin
            opb_nine[4*i +: 4]  = 4'd9 - opb_mag[4*i +: 4];
            sum1_nine[4*i +: 4] = 4'd9 - sum1[4*i +: 4];
        end
    end

    assign add_y = same_sign ? opb_mag : opb_nine;

    // magnitude sum, or A plus the ten's complement of B
    dalu_bcd_add #(.DIGITS(DIGITS)) u_add_main (
        .x    (a_mag),
        .y    (add_y),
        .cin  (!same_sign),
        .s    (sum1),
        .cout (c1)
    );

    // recomplement when B was larger than A
    dalu_bcd_add #(.DIGITS(DIGITS)) u_add_recomp (
        .x    (sum1_nine),
        .y    ('0),
        .cin  (1'b1),
        .s    (sum2),
        .cout (c2_unused)
    );

    dalu_dshift #(.DIGITS(DIGITS)) u_shift (
        .din     (a_mag),
        .count   (imm),
        .to_left (op == FN_SHL),
        .dout    (sh_out)
    );

    // result selection and flags
    always_comb begin
        nx_mag  = '0;
        nx_sign = 1'b0;
        nx_ovf  = 1'b0;
        unique case (op)
            FN_ADD, FN_SUB: begin
                if (same_sign) begin
                    nx_mag  = sum1;
                    nx_sign = a_sign;
                    nx_ovf  = c1;
                end else if (c1) begin
                    nx_mag  = sum1;
                    nx_sign = a_sign;
                end else begin
                    nx_mag  = sum2;
                    nx_sign = opb_neg;
                end
            end
            FN_SHL, FN_SHR: begin
                nx_mag  = sh_out;
                nx_sign = a_sign;
            end
            default: ;
        endcase
        if (bad) begin
            nx_mag  = '0;
            nx_sign = 1'b0;
            nx_ovf  = 1'b0;
        end
        nx_zero = (nx_mag == '0);
        if (nx_zero) begin
            nx_sign = 1'b0;
        end
        nx_pos = !nx_sign && !nx_zero;
    end

    // state register
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_mag   <= '0;
            res_sign  <= 1'b0;
            flag_zero <= 1'b1;
            flag_pos  <= 1'b0;
            flag_ovf  <= 1'b0;
            flag_bad  <= 1'b0;
        end else if (in_valid) begin
            res_mag   <= nx_mag;
            res_sign  <= nx_sign;
            flag_zero <= nx_zero;
            flag_pos  <= nx_pos;
            flag_ovf  <= nx_ovf;
            flag_bad  <= bad;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    // assertions
    logic res_ok;
    dalu_bcd_check #(.DIGITS(DIGITS)) u_chk_res (.value(res_mag), .ok(res_ok));

    a_r1_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        res_ok);

    a_r3_shift_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn[1]) |=> !flag_ovf);

    a_r7_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> !res_sign);

    a_r8_pos_excl: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pos |-> (!flag_zero && !res_sign));

    a_r9_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flag_bad |-> (res_mag == '0 && flag_zero && !flag_ovf && !flag_pos));

    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_mag) && $stable(res_sign)
                       && $stable(flag_zero) && $stable(flag_ovf) && $stable(flag_bad)));

endmodule

// File: tb/dalu_top_tb_top.sv
module dalu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fn = 2'b00;
    logic        a_sign = 1'b0;
    logic [15:0] a_mag = '0;
    logic        b_sign = 1'b0;
    logic [15:0] b_mag = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  imm = '0;
    logic        out_valid, res_sign, flag_zero, flag_pos, flag_ovf, flag_bad;
    logic [15:0] res_mag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dalu_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn(fn),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .use_imm(use_imm), .imm(imm), .out_valid(out_valid),
        .res_sign(res_sign), .res_mag(res_mag), .flag_zero(flag_zero),
        .flag_pos(flag_pos), .flag_ovf(flag_ovf), .flag_bad(flag_bad)
    );

    function automatic bit nib_ok(logic [15:0] v);
        for (int i = 0; i < 4; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int bcd2int(logic [15:0] v);
        int r = 0;
        for (int i = 3; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [15:0] int2bcd(int v);
        logic [15:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    // packed as {sign, mag, zero, pos, ovf, bad}
    function automatic logic [20:0] model(logic [1:0] f, logic as, logic [15:0] am,
                                          logic bs, logic [15:0] bm, logic ui, logic [3:0] im);
        bit arith = (f[1] == 1'b0);
        bit bad;
        int av, bv, r, mag, p;
        bit sg = 1'b0, ovf = 1'b0;
        bad = !nib_ok(am) || (arith && !ui && !nib_ok(bm)) || ((!arith || ui) && im > 4'd9);
        if (bad) return {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1};
        av = as ? -bcd2int(am) : bcd2int(am);
        if (arith) begin
            bv = ui ? int'(im) : (bs ? -bcd2int(bm) : bcd2int(bm));
            r = (f == 2'b00) ? av + bv : av - bv;
            mag = (r < 0) ? -r : r;
            ovf = (mag > 9999);
            mag = mag % 10000;
            sg = (r < 0);
        end else begin
            p = 1;
            for (int i = 0; i < int'(im); i++) p = p * 10;
            if (im >= 4'd4) mag = 0;
            else if (f == 2'b10) mag = (bcd2int(am) * p) % 10000;
            else mag = bcd2int(am) / p;
            sg = as;
        end
        if (mag == 0) sg = 1'b0;
        return {sg, int2bcd(mag), (mag == 0), (!sg && mag != 0), ovf, 1'b0};
    endfunction

    task automatic check(string req, logic [20:0] exp);
        logic [20:0] got = {res_sign, res_mag, flag_zero, flag_pos, flag_ovf, flag_bad};
        n_tests++;
        if (got !== exp || out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: got %h valid %b, expected %h valid 1", req, got, out_valid, exp);
        end
    endtask

    task automatic run_op(string req, logic [1:0] f, logic as, logic [15:0] am,
                          logic bs, logic [15:0] bm, logic ui, logic [3:0] im);
        @(negedge clk);
        in_valid = 1'b1; fn = f; a_sign = as; a_mag = am;
        b_sign = bs; b_mag = bm; use_imm = ui; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, model(f, as, am, bs, bm, ui, im));
    endtask

    function automatic logic [15:0] rnd_bcd();
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            if ($urandom % 20 == 0) v[4*i +: 4] = 4'($urandom);
            else v[4*i +: 4] = 4'($urandom % 10);
        end
        return v;
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [20:0] held;
        int seed_val;
        seed_val = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R11 reset state
        n_tests++;
        if ({out_valid, res_sign, res_mag, flag_zero, flag_pos, flag_ovf, flag_bad} !== {1'b0, 1'b0, 16'h0, 1'b1, 3'b000}) begin
            n_fail++;
            $display("FAIL R11: got %b %h, expected reset values", out_valid, res_mag);
        end
        rst_n = 1'b1;

        run_op("R1 add", 2'b00, 0, 16'h1234, 0, 16'h0766, 0, 0);
        run_op("R3 wrap", 2'b00, 0, 16'h9999, 0, 16'h0001, 0, 0);
        run_op("R3 neg wrap", 2'b00, 1, 16'h9999, 1, 16'h0001, 0, 0);
        run_op("R2 negative", 2'b01, 0, 16'h0005, 0, 16'h0008, 0, 0);
        run_op("R2 minus neg", 2'b01, 1, 16'h0003, 1, 16'h0010, 0, 0);
        run_op("R6 imm sub zero", 2'b01, 0, 16'h0005, 1, 16'hFFFF, 1, 4'd5);
        run_op("R7 neg zero in", 2'b00, 1, 16'h0000, 1, 16'h0000, 0, 0);
        run_op("R4 shl 2", 2'b10, 0, 16'h0012, 1, 16'hABCD, 0, 4'd2);
        run_op("R4 shl lost", 2'b10, 1, 16'h1234, 0, 16'h0000, 1, 4'd2);
        run_op("R4 shl 4", 2'b10, 0, 16'h9999, 0, 16'h0000, 0, 4'd4);
        run_op("R5 shr 2", 2'b11, 0, 16'h0400, 0, 16'h0000, 0, 4'd2);
        run_op("R5 shr 1", 2'b11, 1, 16'h0400, 0, 16'h0000, 0, 4'd1);
        run_op("R5 shr 9", 2'b11, 0, 16'h9999, 0, 16'h0000, 0, 4'd9);
        run_op("R9 bad a", 2'b00, 0, 16'h00A1, 0, 16'h0001, 0, 0);
        run_op("R9 bad imm", 2'b11, 0, 16'h0100, 0, 16'h0000, 0, 4'hC);
        run_op("R9 bad b", 2'b01, 0, 16'h0100, 0, 16'h0F00, 0, 0);
        run_op("R8 pos", 2'b01, 0, 16'h0100, 1, 16'h0001, 0, 0);

        // R10 hold: idle cycles with changed inputs must not move outputs
        held = {res_sign, res_mag, flag_zero, flag_pos, flag_ovf, flag_bad};
        @(negedge clk);
        fn = 2'b00; a_mag = 16'h4444; b_mag = 16'h1111;
        @(negedge clk);
        n_tests++;
        if ({res_sign, res_mag, flag_zero, flag_pos, flag_ovf, flag_bad} !== held || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: got %h valid %b, expected %h valid 0",
                     {res_sign, res_mag, flag_zero, flag_pos, flag_ovf, flag_bad}, out_valid, held);
        end

        for (int n = 0; n < 600; n++) begin
            logic [1:0] f = 2'($urandom);
            logic [3:0] im = ($urandom % 16 == 0) ? 4'($urandom) : 4'($urandom % 10);
            string req = (f == 2'b00) ? "R1 rand add" : (f == 2'b01) ? "R2 rand sub"
                       : (f == 2'b10) ? "R4 rand shl" : "R5 rand shr";
            run_op(req, f, 1'($urandom), rnd_bcd(), 1'($urandom), rnd_bcd(), 1'($urandom), im);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule